// File: doc/BRIEF.md
# Limit Comparator with Sticky Interrupt Status

This block watches five measurement channels. They are an internal temperature, an external channel that carries either a temperature or input 1, and voltage inputs 2, 3 and 4. Each time a channel delivers a fresh conversion result, the block compares that result with the channel's high and low limits. Any out-of-limit event sets a bit in an 8-bit status byte. A bit that has been set stays set. It is released only when software reads the status while the offending condition is no longer present, or when a software reset occurs.

A mask byte gates the status bits onto a single interrupt line, and the polarity of that line is selectable. Temperature channels are compared as signed two's-complement values and voltage channels as unsigned values. The external sensor fault detector lies outside the block and supplies only a level flag.

Top module: `limit_watch`

## Requirements
- R1: After reset the status byte is 00h and the interrupt line is inactive.
- R2: A high event occurs when a result is strictly greater than its high limit. On the internal channel this sets status bit 0, and a result equal to the limit sets nothing.
- R3: A low event occurs when a result is less than or equal to its low limit. On the internal channel this sets status bit 1, and a result equal to the limit does set the bit.
- R4: The internal channel, and the external channel in temperature mode, compare as signed two's-complement values. A negative result is below a zero low limit and not above a positive high limit.
- R5: With ext_volt=0 (temperature mode), lane 1 sets bit 2 on a high event and bit 3 on a low event.
- R6: With ext_volt=1 (voltage mode), lane 1 compares unsigned and sets bit 2 on either a high or a low event. Bit 3 is never set in this mode.
- R7: Lanes 2, 3 and 4 compare unsigned and set bits 5, 6 and 7 respectively on either a high or a low event.
- R8: The fault flag sets status bit 4 while it is high.
- R9: A set status bit stays set through later in-range results until a qualifying read.
- R10: A one-cycle pulse on stat_rd clears exactly those set bits whose latest condition is in range. An event arriving in the same cycle as the read leaves its bit set.
- R11: A pulse on soft_rst clears the status byte, and this takes priority over events in the same cycle.
- R12: The interrupt is pending when any status bit is set whose mask bit is 0. irq equals the pending state when irq_high=1 and its inverse when irq_high=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software clear |
| ext_volt | input | 1 | Lane 1 mode: 0 temperature, 1 voltage input 1 |
| res_val | input | 5*W | Results, lane k at [k*W +: W]: 0 internal, 1 external/input 1, 2..4 inputs 2..4 |
| res_upd | input | 5 | One strobe per lane, marking a fresh result |
| lim_hi | input | 5*W | High limits, same lane layout |
| lim_lo | input | 5*W | Low limits, same lane layout |
| fault | input | 1 | External sensor open/short flag |
| mask | input | 8 | 1 suppresses the matching status bit from irq |
| irq_high | input | 1 | Interrupt polarity: 1 active high |
| stat_rd | input | 1 | Status read strobe |
| status | output | 8 | Sticky status byte |
| irq | output | 1 | Interrupt line |

## Verification
A status read and a fresh out-of-limit result can arrive in the same clock cycle. The bench provokes this by pulsing stat_rd together with an update strobe on a different lane, while another bit is set and already back in range. It then expects the corrected bit to clear and the new event bit to survive. The interaction between a software reset and a still-present condition is also judged at the status byte.

// File: rtl/limit_watch.sv
module limit_watch #(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           ext_volt,
  input  logic [5*W-1:0] res_val,
  input  logic [4:0]     res_upd,
  input  logic [5*W-1:0] lim_hi,
  input  logic [5*W-1:0] lim_lo,
  input  logic           fault,
  input  logic [7:0]     mask,
  input  logic           irq_high,
  input  logic           stat_rd,
  output logic [7:0]     status,
  output logic           irq
);
  localparam int NCH = 5;

  logic [NCH-1:0] gt_s, le_s, gt_u, le_u;
  logic [7:0] hit, upd8, evt, cond_q, sts;
  logic pend;

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    wire [W-1:0] v = res_val[k*W +: W];
    wire [W-1:0] h = lim_hi[k*W +: W];
    wire [W-1:0] l = lim_lo[k*W +: W];
    assign gt_s[k] = $signed(v) >  $signed(h);
    assign le_s[k] = $signed(v) <= $signed(l);
    assign gt_u[k] = v >  h;
    assign le_u[k] = v <= l;
  end

  assign hit[0] = gt_s[0];
  assign hit[1] = le_s[0];
  assign hit[2] = ext_volt ? (gt_u[1] | le_u[1]) : gt_s[1];
  assign hit[3] = !ext_volt && le_s[1];
  assign hit[4] = fault;
  assign hit[5] = gt_u[2] | le_u[2];
  assign hit[6] = gt_u[3] | le_u[3];
  assign hit[7] = gt_u[4] | le_u[4];

  assign upd8 = {res_upd[4], res_upd[3], res_upd[2], 1'b1,
                 res_upd[1], res_upd[1], res_upd[0], res_upd[0]};
  assign evt  = hit & upd8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts    <= '0;
      cond_q <= '0;
    end else if (soft_rst) begin
      sts    <= '0;
      cond_q <= '0;
    end else begin
      cond_q <= (cond_q & ~upd8) | evt;
      sts    <= (stat_rd ? (sts & cond_q) : sts) | evt;
    end
  end

  assign status = sts;
  assign pend   = |(sts & ~mask);
  assign irq    = irq_high ? pend : !pend;

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !soft_rst) |=> (($past(status) & ~status) == 8'h00));

  // R10
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !soft_rst) |=> ((status & $past(sts & cond_q)) == $past(sts & cond_q)));

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == 8'h00));

  // R8
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !soft_rst) |=> status[4]);

  // R12
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'hFF) |-> (irq == !irq_high));
endmodule

// File: tb/test_limit_watch.sv
module test_limit_watch;
  localparam int W = 10;
  logic clk = 0, rst_n = 0, soft_rst = 0, ext_volt = 0, fault = 0, irq_high = 1, stat_rd = 0;
  logic [5*W-1:0] res_val = '0, lim_hi = '0, lim_lo = '0;
  logic [4:0] res_upd = '0;
  logic [7:0] mask = '0, status;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  limit_watch #(.W(W)) i_limit_watch (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic put(int lane, int val);
    @(negedge clk);
    res_val[lane*W +: W] = W'(val);
    res_upd[lane] = 1;
    @(negedge clk);
    res_upd = '0;
  endtask

  task automatic rd();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic lims(int lane, int h, int l);
    lim_hi[lane*W +: W] = W'(h);
    lim_lo[lane*W +: W] = W'(l);
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_high();
    put(0, 100); check("R2 equal high", status, 8'h00);
    put(0, 101); check("R2 above high", status, 8'h01);
    put(0, 50);  check("R9 sticky", status, 8'h01);
    rd();        check("R9 read clears", status, 8'h00);
  endtask

  task automatic t_low();
    put(0, 1); check("R3 above low", status, 8'h00);
    put(0, 0); check("R3 equal low", status, 8'h02);
    put(0, 50); rd(); check("R3 cleared", status, 8'h00);
  endtask

  task automatic t_signed();
    put(0, -5); check("R4 negative", status, 8'h02);
    put(0, 50); rd(); check("R4 cleared", status, 8'h00);
  endtask

  task automatic t_ext_temp();
    put(1, 101); check("R5 ext high", status, 8'h04);
    put(1, 50); rd();
    put(1, 0); check("R5 ext low", status, 8'h08);
    put(1, 50); rd(); check("R5 cleared", status, 8'h00);
  endtask

  task automatic t_ext_volt();
    ext_volt = 1; lims(1, 500, 10);
    put(1, 501); check("R6 v high", status, 8'h04);
    put(1, 50); rd();
    put(1, 10); check("R6 v low", status, 8'h04);
    put(1, 50); rd();
    put(1, 600); check("R6 unsigned", status, 8'h04);
    put(1, 50); rd(); check("R6 cleared", status, 8'h00);
    ext_volt = 0; lims(1, 100, 0);
  endtask

  task automatic t_ains();
    put(2, 501); put(3, 10); put(4, 700);
    check("R7 ains", status, 8'hE0);
    put(2, 50); put(3, 50); put(4, 50); rd();
    check("R7 cleared", status, 8'h00);
  endtask

  task automatic t_fault();
    @(negedge clk); fault = 1;
    @(negedge clk); check("R8 fault", status, 8'h10);
    rd(); check("R8 held fault", status, 8'h10);
    fault = 0; rd(); check("R8 cleared", status, 8'h00);
  endtask

  task automatic t_read_race();
    put(0, 101); put(2, 501); check("R10 two set", status, 8'h21);
    put(2, 50); rd(); check("R10 partial", status, 8'h01);
    put(0, 50);
    @(negedge clk);
    stat_rd = 1; res_val[3*W +: W] = W'(10); res_upd[3] = 1;
    @(negedge clk);
    stat_rd = 0; res_upd = '0;
    check("R10 same cycle", status, 8'h40);
    put(3, 50); rd(); check("R10 cleared", status, 8'h00);
  endtask

  task automatic t_soft();
    put(0, 101); check("R11 set", status, 8'h01);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    check("R11 cleared", status, 8'h00);
    rd(); check("R11 stays", status, 8'h00);
  endtask

  task automatic t_irq();
    put(0, 101);
    check("R12 active high", {7'd0, irq}, 8'h01);
    @(negedge clk); mask = 8'h01; #1;
    check("R12 masked", {7'd0, irq}, 8'h00);
    irq_high = 0; #1;
    check("R12 low idle", {7'd0, irq}, 8'h01);
    mask = 8'h00; #1;
    check("R12 active low", {7'd0, irq}, 8'h00);
    put(0, 50); rd(); irq_high = 1; #1;
    check("R12 released", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    lims(0, 100, 0); lims(1, 100, 0);
    lims(2, 500, 10); lims(3, 500, 10); lims(4, 500, 10);
    for (int k = 0; k < 5; k++) res_val[k*W +: W] = W'(50);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_high(); t_low(); t_signed(); t_ext_temp(); t_ext_volt();
    t_ains(); t_fault(); t_read_race(); t_soft(); t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule